// File: doc/BRIEF.md
# Unified Address Translation Lookup Buffer

This block holds a set of translation entries (64 by default), each mapping a virtual page to a physical page. Every entry carries a validity flag, a page-size code, a sharing flag, two protection bits, a dirty flag and an address-space tag. A lookup is purely combinational. It takes a 32-bit virtual address, the privilege level, the current address-space tag and a single-virtual-space flag. From these it reports one of three results (hit, miss or multi-hit), the translated physical address, and the index and attributes of the matching entry.

Entries are loaded one at a time through a write port. A flush input invalidates every entry in one cycle. A replacement counter advances on each lookup strobe and wraps back to zero at a boundary value supplied by the caller. Software can use this counter to choose a victim slot. Permission checking is left to the consumer, which reads the returned protection and dirty bits.

Top module: `utlb_lookup`

## Requirements
- R1: An entry whose validity flag is 0 never contributes to a lookup result.
- R2: The size code selects the compared virtual bits: code 0 compares bits 31:10 (1 KB), code 1 bits 31:12 (4 KB), code 2 bits 31:16 (64 KB), code 3 bits 31:20 (1 MB). The stored page number holds address bits 31:10.
- R3: The address-space tag of an entry must equal `lk_asid` only when the entry's sharing flag is 0 and either `lk_priv` is 0 or `lk_sv` is 0. In every other case the tag is not compared.
- R4: When two or more entries match, `lk_multi` is 1 and `lk_hit` is 0. Address, index and attributes are then undefined.
- R5: When no entry matches, `lk_miss` is 1. While `lk_en` is 1, exactly one of hit, miss and multi is 1.
- R6: On a hit, `lk_pa` is the stored physical page (address bits 28:10) masked by the page size, merged with the virtual bits below the page size.
- R7: On a hit, `lk_idx` gives the entry number, and `lk_pr`, `lk_d` and `lk_sh` give that entry's fields.
- R8: At each clock edge with `lk_en` 1, `urc` increments modulo 64. If the incremented value equals `urb`, `urc` becomes 0 instead.
- R9: At an edge with `lk_en` 0, `urc` keeps its value.
- R10: A flush clears every validity flag. At the same edge a write is discarded, because flush has priority.
- R11: A write with `wr_en` 1 loads all fields of entry `wr_idx` at the clock edge. A lookup made in the cycle of the write still sees the old contents.
- R12: After reset all entries are invalid and `urc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry to load |
| wr_vpn | input | 22 | Virtual page, address bits 31:10 |
| wr_asid | input | 8 | Address-space tag |
| wr_ppn | input | 19 | Physical page, address bits 28:10 |
| wr_v | input | 1 | Validity flag |
| wr_sz | input | 2 | Page-size code |
| wr_sh | input | 1 | Sharing flag |
| wr_pr | input | 2 | Protection bits |
| wr_d | input | 1 | Dirty flag |
| flush | input | 1 | Invalidate all entries |
| urb | input | 6 | Replacement counter wrap boundary |
| lk_en | input | 1 | Lookup strobe, advances counter |
| lk_va | input | 32 | Virtual address to translate |
| lk_priv | input | 1 | 1 = privileged mode |
| lk_asid | input | 8 | Current address-space tag |
| lk_sv | input | 1 | Single-virtual-space flag |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | Several entries matched |
| lk_pa | output | 29 | Translated physical address |
| lk_idx | output | 6 | Matching entry number |
| lk_pr | output | 2 | Protection bits of the match |
| lk_d | output | 1 | Dirty flag of the match |
| lk_sh | output | 1 | Sharing flag of the match |
| urc | output | 6 | Replacement counter |

## Verification
The bench probes addresses just inside and just outside each of the four page sizes. A wrong mask width would show up here as a hit on a neighbouring page or as a wrong low-order merge in the physical address. It tries all combinations of privilege and single-virtual flag against shared and private entries with a foreign tag, so an inverted tag-bypass term turns a miss into a hit. Two overlapping entries expose a design that reports the first match instead of a multi-hit, and an invalid entry with a matching tag catches a design that ignores the validity flag. The counter runs through several wrap boundaries and through idle cycles, and a flush issued together with a write catches write-over-flush priority.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 29;
    localparam int ASID_W     = 8;
    localparam int BASE_SHIFT = 10;
    localparam int VPN_W      = VA_W - BASE_SHIFT;
    localparam int PPN_W      = PA_W - BASE_SHIFT;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_sz_e;

    typedef struct packed {
        logic              v;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        pg_sz_e            sz;
        logic              sh;
        logic [1:0]        pr;
        logic              d;
    } tlb_ent_t;

    // Mask of the virtual bits that take part in the compare
    function automatic logic [VA_W-1:0] page_mask(pg_sz_e sz);
        logic [VA_W-1:0] ones;
        ones = '1;
        case (sz)
            PG_1K:   return ones << 10;
            PG_4K:   return ones << 12;
            PG_64K:  return ones << 16;
            default: return ones << 20;
        endcase
    endfunction
endpackage

// File: rtl/utlb_store.sv
module utlb_store
    import utlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_ent_t             wr_ent,
    input  logic                 flush,
    output tlb_ent_t [N_ENT-1:0] ents
);
    logic [N_ENT-1:0] valid_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else if (flush) begin
            for (int i = 0; i < N_ENT; i++) ents[i].v <= 1'b0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end

    always_comb begin
        for (int i = 0; i < N_ENT; i++) valid_vec[i] = ents[i].v;
    end

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R11
    write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> (ents[$past(wr_idx)] == $past(wr_ent)));
endmodule

// File: rtl/utlb_match_cell.sv
module utlb_match_cell
    import utlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VA_W-1:0]   va,
    input  logic              priv,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              sv,
    output logic              hit,
    output logic [PA_W-1:0]   pa
);
    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] vbase;
    logic [VA_W-1:0] pbase;
    logic            need_tag;
    logic            tag_ok;

    always_comb begin
        mask     = page_mask(ent.sz);
        vbase    = {ent.vpn, {BASE_SHIFT{1'b0}}};
        pbase    = VA_W'({ent.ppn, {BASE_SHIFT{1'b0}}});
        need_tag = !ent.sh && (!priv || !sv);
        tag_ok   = !need_tag || (ent.asid == cur_asid);
        hit      = ent.v && (((vbase ^ va) & mask) == '0) && tag_ok;
        pa       = PA_W'((pbase & mask) | (va & ~mask));
    end
endmodule

// File: rtl/utlb_repl_ctr.sv
module utlb_repl_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] bound,
    output logic [W-1:0] cnt
);
    logic [W-1:0] nxt;

    always_comb nxt = cnt + W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= (nxt == bound) ? '0 : nxt;
    end

    // R8
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (cnt == '0) || (cnt == $past(cnt) + W'(1)));

    // R9
    ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/utlb_lookup.sv
module utlb_lookup
    import utlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_v,
    input  logic [1:0]        wr_sz,
    input  logic              wr_sh,
    input  logic [1:0]        wr_pr,
    input  logic              wr_d,
    input  logic              flush,
    input  logic [IDX_W-1:0]  urb,
    input  logic              lk_en,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              lk_priv,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_sv,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic [PA_W-1:0]   lk_pa,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [1:0]        lk_pr,
    output logic              lk_d,
    output logic              lk_sh,
    output logic [IDX_W-1:0]  urc
);
    tlb_ent_t                wr_ent;
    tlb_ent_t [N_ENT-1:0]    ents;
    logic     [N_ENT-1:0]    hits;
    logic     [PA_W-1:0]     cell_pa [N_ENT];

    always_comb begin
        wr_ent      = '0;
        wr_ent.v    = wr_v;
        wr_ent.vpn  = wr_vpn;
        wr_ent.asid = wr_asid;
        wr_ent.ppn  = wr_ppn;
        wr_ent.sz   = pg_sz_e'(wr_sz);
        wr_ent.sh   = wr_sh;
        wr_ent.pr   = wr_pr;
        wr_ent.d    = wr_d;
    end

    utlb_store #(.N_ENT(N_ENT)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .flush(flush), .ents(ents)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_cell
        utlb_match_cell u_cell (
            .ent(ents[g]), .va(lk_va), .priv(lk_priv), .cur_asid(lk_asid),
            .sv(lk_sv), .hit(hits[g]), .pa(cell_pa[g])
        );
    end

    // OR-merge of the single matching entry; contents undefined on multi-hit
    logic any, dup;
    always_comb begin
        any    = 1'b0;
        dup    = 1'b0;
        lk_idx = '0;
        lk_pa  = '0;
        lk_pr  = '0;
        lk_d   = 1'b0;
        lk_sh  = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hits[i]) begin
                dup    = dup | any;
                any    = 1'b1;
                lk_idx = lk_idx | IDX_W'(i);
                lk_pa  = lk_pa | cell_pa[i];
                lk_pr  = lk_pr | ents[i].pr;
                lk_d   = lk_d | ents[i].d;
                lk_sh  = lk_sh | ents[i].sh;
            end
        end
        lk_hit   = any && !dup;
        lk_multi = dup;
        lk_miss  = !any;
    end

    utlb_repl_ctr #(.W(IDX_W)) u_ctr (
        .clk(clk), .rst(rst), .adv(lk_en), .bound(urb), .cnt(urc)
    );

    // R5
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        lk_en |-> ($countones({lk_hit, lk_miss, lk_multi}) == 1));

    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[BASE_SHIFT-1:0] == lk_va[BASE_SHIFT-1:0]));

    // R10
    no_match_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> lk_miss);
endmodule

// File: tb/utlb_lookup_tb.sv
module utlb_lookup_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        wr_en = 0, wr_v = 0, wr_sh = 0, wr_d = 0, flush = 0;
    logic [5:0]  wr_idx = 0, urb = 0;
    logic [21:0] wr_vpn = 0;
    logic [7:0]  wr_asid = 0, lk_asid = 0;
    logic [18:0] wr_ppn = 0;
    logic [1:0]  wr_sz = 0, wr_pr = 0;
    logic        lk_en = 0, lk_priv = 0, lk_sv = 0;
    logic [31:0] lk_va = 0;
    logic        lk_hit, lk_miss, lk_multi, lk_d, lk_sh;
    logic [28:0] lk_pa;
    logic [5:0]  lk_idx, urc;
    logic [1:0]  lk_pr;

    utlb_lookup u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_v(wr_v), .wr_sz(wr_sz),
        .wr_sh(wr_sh), .wr_pr(wr_pr), .wr_d(wr_d), .flush(flush), .urb(urb),
        .lk_en(lk_en), .lk_va(lk_va), .lk_priv(lk_priv), .lk_asid(lk_asid),
        .lk_sv(lk_sv), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
        .lk_pa(lk_pa), .lk_idx(lk_idx), .lk_pr(lk_pr), .lk_d(lk_d),
        .lk_sh(lk_sh), .urc(urc)
    );

    // Behavioural reference
    bit          mv [64];
    logic [21:0] mvpn [64];
    logic [7:0]  masid [64];
    logic [18:0] mppn [64];
    int          msz [64];
    bit          msh [64], md [64];
    logic [1:0]  mpr [64];
    int          murc = 0;
    int          total = 0, bad = 0;
    string       tag = "R12";

    function automatic logic [31:0] mask_of(int sz);
        int sh;
        sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
        return 32'hFFFF_FFFF << sh;
    endfunction

    task automatic chk(string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        int nm, mi;
        logic [31:0] m, epa;
        #5;
        nm = 0; mi = 0; epa = 0;
        for (int i = 0; i < 64; i++) begin
            m = mask_of(msz[i]);
            if (mv[i] && ((({mvpn[i], 10'd0} ^ lk_va) & m) == 0) &&
                (msh[i] || (lk_priv && lk_sv) || masid[i] == lk_asid)) begin
                nm++; mi = i;
                epa = (({13'd0, mppn[i], 10'd0}) & m) | (lk_va & ~m);
            end
        end
        chk("urc", urc, murc);
        if (lk_en) begin
            chk("hit", lk_hit, nm == 1);
            chk("miss", lk_miss, nm == 0);
            chk("multi", lk_multi, nm > 1);
            if (nm == 1) begin
                chk("pa", lk_pa, epa[28:0]);
                chk("idx", lk_idx, mi);
                chk("pr", lk_pr, mpr[mi]);
                chk("d", lk_d, md[mi]);
                chk("sh", lk_sh, msh[mi]);
            end
        end
        if (flush) begin
            for (int i = 0; i < 64; i++) mv[i] = 0;
        end else if (wr_en) begin
            mv[wr_idx] = wr_v; mvpn[wr_idx] = wr_vpn; masid[wr_idx] = wr_asid;
            mppn[wr_idx] = wr_ppn; msz[wr_idx] = wr_sz; msh[wr_idx] = wr_sh;
            mpr[wr_idx] = wr_pr; md[wr_idx] = wr_d;
        end
        if (lk_en) begin
            murc = (murc + 1) % 64;
            if (murc == urb) murc = 0;
        end
        @(negedge clk);
    endtask

    task automatic wr(int idx, logic [31:0] va, logic [7:0] asid, logic [28:0] pa,
                      bit v, int sz, bit sh, logic [1:0] pr, bit d);
        wr_en = 1; wr_idx = idx[5:0]; wr_vpn = va[31:10]; wr_asid = asid;
        wr_ppn = pa[28:10]; wr_v = v; wr_sz = sz[1:0]; wr_sh = sh; wr_pr = pr; wr_d = d;
        tick();
        wr_en = 0;
    endtask

    task automatic lk(string t, logic [31:0] va, bit priv, logic [7:0] asid, bit sv);
        tag = t; lk_en = 1; lk_va = va; lk_priv = priv; lk_asid = asid; lk_sv = sv;
        tick();
        lk_en = 0;
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mv[i] = 0; mvpn[i] = 0; masid[i] = 0; mppn[i] = 0;
            msz[i] = 0; msh[i] = 0; md[i] = 0; mpr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state: miss everywhere, counter 0
        lk("R12", 32'h0012_3400, 1, 8'd5, 0);

        // R11 entries of each size
        tag = "R11";
        wr(0,  32'h0012_3400, 8'd5, 29'h0ABC_D400, 1, 0, 0, 2'b11, 1);
        wr(1,  32'h0040_0000, 8'd9, 29'h0100_0000, 1, 1, 1, 2'b01, 0);
        wr(2,  32'h0100_0000, 8'd5, 29'h0123_0000, 1, 2, 0, 2'b10, 1);
        wr(63, 32'h0A00_0000, 8'd7, 29'h1F50_0000, 1, 3, 0, 2'b00, 0);
        wr(5,  32'h0030_0000, 8'd5, 29'h0000_0000, 0, 3, 1, 2'b11, 1);

        // R2 and R6: inside and just outside each page size
        lk("R2",  32'h0012_37FC, 0, 8'd5, 0);
        lk("R2",  32'h0012_3800, 0, 8'd5, 0);
        lk("R6",  32'h0040_0FFE, 0, 8'd1, 0);
        lk("R2",  32'h0040_1000, 0, 8'd1, 0);
        lk("R6",  32'h0100_FFF0, 0, 8'd5, 0);
        lk("R2",  32'h0101_0000, 0, 8'd5, 0);
        lk("R6",  32'h0A0F_ABCD, 1, 8'd7, 0);
        lk("R2",  32'h0A10_0000, 1, 8'd7, 0);
        // R1 invalid entry never matches
        lk("R1",  32'h0030_1234, 1, 8'd5, 1);
        // R3 tag rule with foreign tag on private entry
        lk("R3",  32'h0012_3404, 0, 8'd6, 0);
        lk("R3",  32'h0012_3404, 0, 8'd6, 1);
        lk("R3",  32'h0012_3404, 1, 8'd6, 0);
        lk("R3",  32'h0012_3404, 1, 8'd6, 1);
        // R3 shared entry ignores the tag
        lk("R3",  32'h0040_0010, 0, 8'd200, 0);
        // R7 attributes and index
        lk("R7",  32'h0A05_0000, 0, 8'd7, 1);
        // R4 overlapping entries
        tag = "R4";
        wr(10, 32'h0012_0000, 8'd5, 29'h0000_8000, 1, 2, 0, 2'b11, 0);
        lk("R4",  32'h0012_3400, 0, 8'd5, 0);
        lk("R4",  32'h0012_0000, 0, 8'd5, 0);
        // R5 no match at all
        lk("R5",  32'h7000_0000, 1, 8'd0, 1);
        // R11 a lookup in the cycle of a write sees old contents
        tag = "R11";
        wr_en = 1; wr_idx = 20; wr_vpn = 22'h3FFFFF; wr_asid = 0; wr_ppn = 19'h1;
        wr_v = 1; wr_sz = 0; wr_sh = 1; wr_pr = 0; wr_d = 0;
        lk("R11", 32'hFFFF_FC00, 0, 8'd0, 0);
        wr_en = 0;
        lk("R11", 32'hFFFF_FC00, 0, 8'd0, 0);
        // R8 counter wrap with several boundaries
        urb = 6'd5;
        for (int i = 0; i < 12; i++) lk("R8", 32'h0012_3400, 0, 8'd5, 0);
        urb = 6'd0;
        for (int i = 0; i < 70; i++) lk("R8", 32'h0040_0000, 1, 8'd5, 1);
        urb = 6'd1;
        for (int i = 0; i < 3; i++) lk("R8", 32'h0, 1, 8'd5, 1);
        // R9 idle cycles hold counter
        urb = 6'd40;
        tag = "R9";
        repeat (4) tick();
        // randomised lookups over written region
        for (int i = 0; i < 300; i++) begin
            logic [31:0] va;
            va = $urandom;
            case (i % 4)
                0: va = {12'h001, va[19:0]};
                1: va = {12'h004, va[19:0]};
                2: va = {8'h01, va[23:0]};
                default: va = {12'h0A0, va[19:0]};
            endcase
            lk("R6", va, i[1], (i % 3 == 0) ? 8'd5 : 8'd7, i[2]);
        end
        // R10 flush with a concurrent write: write discarded
        tag = "R10";
        flush = 1; wr_en = 1; wr_idx = 30; wr_vpn = 22'h001000; wr_asid = 0;
        wr_ppn = 19'h2; wr_v = 1; wr_sz = 3; wr_sh = 1; wr_pr = 0; wr_d = 0;
        tick();
        flush = 0; wr_en = 0;
        lk("R10", 32'h0040_0000, 1, 8'd0, 1);
        lk("R10", 32'h0012_3400, 0, 8'd5, 0);
        lk("R10", 32'h0A00_0000, 0, 8'd7, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule